// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the two sleep states of a small microcontroller core. A one-cycle software request moves it from normal running into either idle, where the core clock enable is dropped while the oscillator and the peripherals keep going, or power-down, where the oscillator enable is removed as well. It then decides when each state ends. Idle ends on any interrupt that is both pending and enabled. Power-down ends on a hardware reset, or on an external interrupt pin held low. That pin must be enabled, set to level sensitivity, and the global wake-enable bit must be set. A power-down wake restarts the oscillator, waits a programmable stabilization count, and releases the core clock only once the waking pin has also returned high.

A hardware reset that arrives during idle does not reset the core at once. The core briefly runs again, and during that guard window of two machine cycles writes to internal RAM are blocked. After the window the core reset is applied. While a sleep state is active, the block also supplies override values for the address-latch and program-strobe pins, and tells the port logic whether port 0 floats and whether port 2 carries the address. All pins are plain control and status levels. The block carries no data stream, so it has no valid/ready interface and no back-pressure.

Top module: `lpm_ctrl`

## Requirements
- R1: After `rst_n` is released the block is running: `cpu_clk_en_o`=1, `osc_en_o`=1, `pin_ovr_o`=0, `core_rst_o`=0, `ram_wr_block_o`=0, `resume_o`=0.
- R2: In the running state, a one-cycle `idle_req_i` drops `cpu_clk_en_o` to 0 on the next cycle and leaves `osc_en_o`=1. When `idle_req_i` and `pd_req_i` arrive together, power-down is entered.
- R3: Idle ends when some bit k has both `irq_pend_i[k]`=1 and `irq_en_i[k]`=1. On the next cycle `cpu_clk_en_o` returns to 1. A pending request whose enable bit is 0 leaves the block in idle.
- R4: A one-cycle `pd_req_i` in the running state drives `osc_en_o` and `cpu_clk_en_o` to 0 on the next cycle. Enabled pending interrupts on `irq_pend_i` do not end power-down.
- R5: Power-down is left by external interrupt only when `wake_en_i`=1 and some pin k has `ext_en_i[k]`=1, `ext_edge_i[k]`=0 (0 = level, 1 = edge) and `ext_pin_n_i[k]`=0. The pin passes through a two-stage synchronizer. If any of these conditions is missing, a low pin leaves `osc_en_o` at 0.
- R6: Once a wake starts, `osc_en_o` is 1 and `cpu_clk_en_o` stays 0 for at least `stab_cycles_i`+1 cycles. It also stays 0 until every enabled, level-sensitive pin reads high again. Only then does `cpu_clk_en_o` return to 1.
- R7: `resume_o` is high for exactly one cycle: the first running cycle after an interrupt exit from idle or from power-down. A reset exit never raises it.
- R8: `hw_rst_i` during idle starts a guard window of 2*`MC_CLKS` cycles. During the window `ram_wr_block_o`=1, `cpu_clk_en_o`=1 and `core_rst_o`=0. After the window, `core_rst_o`=1 until `hw_rst_i` falls, and the next cycle is a running cycle.
- R9: `hw_rst_i` in the running state or in power-down raises `core_rst_o` and `osc_en_o` on the next cycle with no guard window (`ram_wr_block_o`=0).
- R10: Pin overrides. In idle: `pin_ovr_o`=1 with `ale_o`=1 and `psen_o`=1, and `p0_float_o`=`p2_addr_o`=`ext_prog_i`. In power-down: `ale_o`=0, `psen_o`=0, `p0_float_o`=`ext_prog_i` and `p2_addr_o`=0. While running, all five are 0.
- R11: `idle_req_i` and `pd_req_i` are ignored outside the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| idle_req_i | input | 1 | One-cycle request to enter idle |
| pd_req_i | input | 1 | One-cycle request to enter power-down |
| hw_rst_i | input | 1 | Hardware reset pin level, active high |
| irq_pend_i | input | N_IRQ | Pending interrupt requests |
| irq_en_i | input | N_IRQ | Per-request interrupt enables |
| ext_pin_n_i | input | N_EXT | External interrupt pins, active low, asynchronous |
| ext_en_i | input | N_EXT | External interrupt enables |
| ext_edge_i | input | N_EXT | Sensitivity per pin: 1 edge, 0 level |
| wake_en_i | input | 1 | Allows external-interrupt exit from power-down |
| stab_cycles_i | input | STAB_W | Oscillator stabilization count |
| ext_prog_i | input | 1 | Program memory is external |
| cpu_clk_en_o | output | 1 | Core clock gate enable |
| osc_en_o | output | 1 | Oscillator enable |
| resume_o | output | 1 | One-cycle pulse on interrupt exit |
| core_rst_o | output | 1 | Core reset (special registers reinitialized) |
| ram_wr_block_o | output | 1 | Inhibits internal RAM writes |
| pin_ovr_o | output | 1 | Sleep-state pin override active |
| ale_o | output | 1 | Address-latch pin override value |
| psen_o | output | 1 | Program-strobe pin override value |
| p0_float_o | output | 1 | Port 0 to high impedance |
| p2_addr_o | output | 1 | Port 2 drives address rather than latch data |

## Verification
The bench builds the block with N_IRQ=4, N_EXT=2, STAB_W=8 and MC_CLKS=2. With these values the reset guard window is four cycles, so it can be counted exactly, and a stabilization count of 6 or 3 is short enough to measure cycle by cycle. Using two external pins lets one pin wake the block while the other is set to a disqualifying sensitivity or enable. A pin held low well past the stabilization count shows that the exit waits for the pin to rise.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_PD    = 3'd2,
    ST_WAKE  = 3'd3,
    ST_GUARD = 3'd4,
    ST_RESET = 3'd5
  } lpm_state_e;
endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
  parameter int N_IRQ       = 8,
  parameter int N_EXT       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_EXT-1:0] ext_pin_n,
  input  logic [N_EXT-1:0] ext_en,
  input  logic [N_EXT-1:0] ext_edge,
  input  logic             wake_en,
  output logic             idle_wake,
  output logic             pd_wake_lo,
  output logic             pd_release
);
  logic [N_EXT-1:0] pin_sync;
  logic [N_EXT-1:0] qual;

  // one synchronizer chain per external pin; idle level is high
  for (genvar k = 0; k < N_EXT; k++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[SYNC_STAGES-2:0], ext_pin_n[k]};
    end
    assign pin_sync[k] = chain[SYNC_STAGES-1];
  end

  assign qual       = ext_en & ~ext_edge;
  assign idle_wake  = |(irq_pend & irq_en);
  assign pd_wake_lo = wake_en & (|(qual & ~pin_sync));
  assign pd_release = &(~qual | pin_sync);
endmodule

// File: rtl/lpm_down_cnt.sv
module lpm_down_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // an expired window stays expired until reloaded
  assert_cnt_stays_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int CW         = 16,
  parameter int GUARD_LOAD = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_req,
  input  logic          pd_req,
  input  logic          hw_rst,
  input  logic          idle_wake,
  input  logic          pd_wake_lo,
  input  logic          pd_release,
  input  logic [CW-1:0] stab_val,
  input  logic          cnt_done,
  output lpm_state_e    state,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          resume
);
  lpm_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN: begin
        if (hw_rst)        nxt = ST_RESET;
        else if (pd_req)   nxt = ST_PD;
        else if (idle_req) nxt = ST_IDLE;
      end
      ST_IDLE: begin
        if (hw_rst)         nxt = ST_GUARD;
        else if (idle_wake) nxt = ST_RUN;
      end
      ST_PD: begin
        if (hw_rst)          nxt = ST_RESET;
        else if (pd_wake_lo) nxt = ST_WAKE;
      end
      ST_WAKE: begin
        if (hw_rst)                      nxt = ST_RESET;
        else if (cnt_done && pd_release) nxt = ST_RUN;
      end
      ST_GUARD: if (cnt_done) nxt = ST_RESET;
      ST_RESET: if (!hw_rst)  nxt = ST_RUN;
      default:  nxt = ST_RUN;
    endcase
  end

  assign cnt_load = ((state == ST_PD) && (nxt == ST_WAKE)) ||
                    ((state == ST_IDLE) && (nxt == ST_GUARD));
  assign cnt_val  = (state == ST_IDLE) ? CW'(GUARD_LOAD) : stab_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_RUN;
      resume <= 1'b0;
    end else begin
      state  <= nxt;
      resume <= (nxt == ST_RUN) && ((state == ST_IDLE) || (state == ST_WAKE));
    end
  end

  assert_idle_exit_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !hw_rst && !idle_wake) |=> state == ST_IDLE);
  assert_pd_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PD && !pd_wake_lo) |=> state != ST_WAKE);
  assert_wake_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE && (!cnt_done || !pd_release)) |=> state != ST_RUN);
  assert_resume_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);
  assert_guard_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && hw_rst) |=> state == ST_GUARD);
  assert_req_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !hw_rst && !idle_wake && pd_req) |=> state == ST_IDLE);
endmodule

// File: rtl/lpm_out_decode.sv
module lpm_out_decode
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  input  logic       ext_prog,
  output logic       cpu_clk_en,
  output logic       osc_en,
  output logic       core_rst,
  output logic       ram_wr_block,
  output logic       pin_ovr,
  output logic       ale,
  output logic       psen,
  output logic       p0_float,
  output logic       p2_addr
);
  always_comb begin
    cpu_clk_en   = 1'b1;
    osc_en       = 1'b1;
    core_rst     = 1'b0;
    ram_wr_block = 1'b0;
    pin_ovr      = 1'b0;
    ale          = 1'b0;
    psen         = 1'b0;
    p0_float     = 1'b0;
    p2_addr      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cpu_clk_en = 1'b0;
        pin_ovr    = 1'b1;
        ale        = 1'b1;
        psen       = 1'b1;
        p0_float   = ext_prog;
        p2_addr    = ext_prog;
      end
      ST_PD, ST_WAKE: begin
        cpu_clk_en = 1'b0;
        osc_en     = (state == ST_WAKE);
        pin_ovr    = 1'b1;
        p0_float   = ext_prog;
      end
      ST_GUARD: ram_wr_block = 1'b1;
      ST_RESET: core_rst     = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int N_IRQ       = 8,
  parameter int N_EXT       = 2,
  parameter int STAB_W      = 16,
  parameter int MC_CLKS     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_req_i,
  input  logic              pd_req_i,
  input  logic              hw_rst_i,
  input  logic [N_IRQ-1:0]  irq_pend_i,
  input  logic [N_IRQ-1:0]  irq_en_i,
  input  logic [N_EXT-1:0]  ext_pin_n_i,
  input  logic [N_EXT-1:0]  ext_en_i,
  input  logic [N_EXT-1:0]  ext_edge_i,
  input  logic              wake_en_i,
  input  logic [STAB_W-1:0] stab_cycles_i,
  input  logic              ext_prog_i,
  output logic              cpu_clk_en_o,
  output logic              osc_en_o,
  output logic              resume_o,
  output logic              core_rst_o,
  output logic              ram_wr_block_o,
  output logic              pin_ovr_o,
  output logic              ale_o,
  output logic              psen_o,
  output logic              p0_float_o,
  output logic              p2_addr_o
);
  localparam int GUARD_CYC = 2 * MC_CLKS;
  localparam int GW        = $clog2(GUARD_CYC) + 1;
  localparam int CW        = (STAB_W > GW) ? STAB_W : GW;

  lpm_state_e    state;
  logic          idle_wake, pd_wake_lo, pd_release;
  logic          cnt_load, cnt_done;
  logic [CW-1:0] cnt_val;

  lpm_wake_detect #(.N_IRQ(N_IRQ), .N_EXT(N_EXT), .SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk(clk), .rst_n(rst_n),
    .irq_pend(irq_pend_i), .irq_en(irq_en_i),
    .ext_pin_n(ext_pin_n_i), .ext_en(ext_en_i), .ext_edge(ext_edge_i),
    .wake_en(wake_en_i),
    .idle_wake(idle_wake), .pd_wake_lo(pd_wake_lo), .pd_release(pd_release)
  );

  lpm_down_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(cnt_load), .load_val(cnt_val), .done(cnt_done)
  );

  lpm_fsm #(.CW(CW), .GUARD_LOAD(GUARD_CYC - 1)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .idle_req(idle_req_i), .pd_req(pd_req_i), .hw_rst(hw_rst_i),
    .idle_wake(idle_wake), .pd_wake_lo(pd_wake_lo), .pd_release(pd_release),
    .stab_val(CW'(stab_cycles_i)), .cnt_done(cnt_done),
    .state(state), .cnt_load(cnt_load), .cnt_val(cnt_val), .resume(resume_o)
  );

  lpm_out_decode u_dec (
    .state(state), .ext_prog(ext_prog_i),
    .cpu_clk_en(cpu_clk_en_o), .osc_en(osc_en_o),
    .core_rst(core_rst_o), .ram_wr_block(ram_wr_block_o),
    .pin_ovr(pin_ovr_o), .ale(ale_o), .psen(psen_o),
    .p0_float(p0_float_o), .p2_addr(p2_addr_o)
  );

  assert_osc_off_only_asleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en_o) |-> (!cpu_clk_en_o && pin_ovr_o));
  assert_reset_no_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |=> !resume_o);
  assert_block_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_block_o |-> (cpu_clk_en_o && !core_rst_o));
endmodule

// File: tb/lpm_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_ctrl_tb;
  localparam int N_IRQ = 4, N_EXT = 2, STAB_W = 8, MC_CLKS = 2;
  localparam int GUARD = 2 * MC_CLKS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_req = 0, pd_req = 0, hw_rst = 0, wake_en = 0, ext_prog = 0;
  logic [N_IRQ-1:0] irq_pend = '0, irq_en = '0;
  logic [N_EXT-1:0] pin_n = '1, ext_en = '0, ext_edge = '0;
  logic [STAB_W-1:0] stab = '0;
  logic cpu_clk_en, osc_en, resume, core_rst, ram_blk, pin_ovr, ale, psen, p0f, p2a;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  lpm_ctrl #(.N_IRQ(N_IRQ), .N_EXT(N_EXT), .STAB_W(STAB_W), .MC_CLKS(MC_CLKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .idle_req_i(idle_req), .pd_req_i(pd_req), .hw_rst_i(hw_rst),
    .irq_pend_i(irq_pend), .irq_en_i(irq_en), .ext_pin_n_i(pin_n), .ext_en_i(ext_en),
    .ext_edge_i(ext_edge), .wake_en_i(wake_en), .stab_cycles_i(stab), .ext_prog_i(ext_prog),
    .cpu_clk_en_o(cpu_clk_en), .osc_en_o(osc_en), .resume_o(resume), .core_rst_o(core_rst),
    .ram_wr_block_o(ram_blk), .pin_ovr_o(pin_ovr), .ale_o(ale), .psen_o(psen),
    .p0_float_o(p0f), .p2_addr_o(p2a)
  );

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_idle(); idle_req = 1; step(); idle_req = 0; endtask
  task automatic pulse_pd();   pd_req = 1;   step(); pd_req = 0;   endtask

  task automatic t_reset();
    chk("R1 cpu_clk_en", cpu_clk_en, 1); chk("R1 osc_en", osc_en, 1);
    chk("R1 pin_ovr", pin_ovr, 0);       chk("R1 core_rst", core_rst, 0);
    chk("R1 ram_blk", ram_blk, 0);       chk("R1 resume", resume, 0);
  endtask

  task automatic t_idle_irq();
    ext_prog = 0;
    pulse_idle();
    chk("R2 cpu off", cpu_clk_en, 0); chk("R2 osc on", osc_en, 1);
    chk("R10 idle int ovr", pin_ovr, 1); chk("R10 idle ale", ale, 1);
    chk("R10 idle psen", psen, 1);       chk("R10 idle p0f", p0f, 0);
    chk("R10 idle p2a", p2a, 0);
    ext_prog = 1; #1;
    chk("R10 idle ext p0f", p0f, 1); chk("R10 idle ext p2a", p2a, 1);
    ext_prog = 0;
    pulse_pd();
    chk("R11 pd_req in idle osc", osc_en, 1);
    irq_pend = 4'b0100; irq_en = 4'b1011;
    repeat (4) step();
    chk("R3 unenabled pend stays idle", cpu_clk_en, 0);
    irq_en = 4'b0100;
    step();
    chk("R3 exit cpu on", cpu_clk_en, 1); chk("R7 resume pulse", resume, 1);
    chk("R10 run ovr", pin_ovr, 0);
    irq_pend = '0; irq_en = '0;
    step();
    chk("R7 resume one cycle", resume, 0);
  endtask

  task automatic t_pd_ignore();
    idle_req = 1; pd_req = 1; step(); idle_req = 0; pd_req = 0;
    chk("R2 pd wins osc", osc_en, 0); chk("R4 cpu off", cpu_clk_en, 0);
    chk("R10 pd ale", ale, 0); chk("R10 pd psen", psen, 0); chk("R10 pd p2a", p2a, 0);
    irq_pend = 4'b0001; irq_en = 4'b0001;
    repeat (4) step();
    chk("R4 irq ignored in pd", osc_en, 0);
    irq_pend = '0; irq_en = '0;
    pulse_idle();
    chk("R11 idle_req in pd", osc_en, 0);
    ext_en = 2'b01; ext_edge = 2'b00; wake_en = 0; pin_n = 2'b10;
    repeat (6) step();
    chk("R5 wake_en=0 ignored", osc_en, 0);
    wake_en = 1; ext_edge = 2'b01;
    repeat (6) step();
    chk("R5 edge mode ignored", osc_en, 0);
    ext_edge = 2'b00; ext_en = 2'b10;
    repeat (6) step();
    chk("R5 disabled pin ignored", osc_en, 0);
    pin_n = 2'b11; ext_en = 2'b00; wake_en = 0;
    repeat (4) step();
  endtask

  task automatic t_pd_wake(input int s, input int hold);
    int n = 0;
    stab = STAB_W'(s); ext_prog = 1;
    pulse_pd();
    chk("R10 pd ext p0f", p0f, 1);
    wake_en = 1; ext_en = 2'b11; ext_edge = 2'b10; pin_n = 2'b10;
    for (int i = 0; i < 10 && !osc_en; i++) step();
    chk("R5 wake osc on", osc_en, 1);
    if (hold > 0) begin
      repeat (hold) step();
      chk("R6 waits for pin high", cpu_clk_en, 0);
      chk("R6 osc held on", osc_en, 1);
      pin_n = 2'b11;
      for (int i = 0; i < 10 && !cpu_clk_en; i++) step();
    end else begin
      pin_n = 2'b11;
      while (!cpu_clk_en && n < 50) begin n++; step(); end
      chk("R6 stabilization cycles", n, s + 1);
    end
    chk("R6 cpu released", cpu_clk_en, 1);
    chk("R7 resume after pd wake", resume, 1);
    step();
    chk("R7 resume cleared", resume, 0);
    wake_en = 0; ext_en = '0; ext_edge = '0; ext_prog = 0;
  endtask

  task automatic t_idle_hw_rst();
    int n = 0;
    pulse_idle();
    hw_rst = 1;
    step();
    while (ram_blk && n < 50) begin
      n++;
      chk("R8 cpu runs in guard", cpu_clk_en, 1);
      chk("R8 no core_rst in guard", core_rst, 0);
      step();
    end
    chk("R8 guard length", n, GUARD);
    chk("R8 core_rst after guard", core_rst, 1);
    step();
    chk("R8 core_rst held", core_rst, 1);
    hw_rst = 0;
    step();
    chk("R8 back to run", core_rst, 0);
    chk("R7 no resume on reset", resume, 0);
  endtask

  task automatic t_pd_hw_rst();
    pulse_pd();
    hw_rst = 1;
    step();
    chk("R9 core_rst from pd", core_rst, 1);
    chk("R9 osc on", osc_en, 1);
    chk("R9 no guard", ram_blk, 0);
    hw_rst = 0; step();
    chk("R7 no resume after pd reset", resume, 0);
    hw_rst = 1; step();
    chk("R9 core_rst from run", core_rst, 1);
    chk("R9 no guard from run", ram_blk, 0);
    hw_rst = 0; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_idle_irq();
    t_pd_ignore();
    t_pd_wake(6, 0);
    t_pd_wake(3, 20);
    t_idle_hw_rst();
    t_pd_hw_rst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule